// File: doc/BRIEF.md
# Load-Keyed Stride Prefetch Table

This block watches the stream of load accesses and learns, for each load instruction, the distance between successive addresses that instruction touches. A small fully associative table is keyed by the program counter of the load. Each entry remembers the last address the load used, the last distance seen and a two-bit confidence counter. Every training strobe carries a program counter and an address. On a match the entry is updated. On a miss a fresh entry is claimed in round-robin order.

Once an instruction's confidence reaches the threshold, the block starts a burst of prefetch addresses. The burst begins a configurable number of strides beyond the current address, so the data can arrive before the load needs it. The burst continues for a configurable number of addresses, each one stride apart. The prefetch addresses leave through a valid/ready handshake toward the memory side.

Top module: `ldpc_stride_pf`

## Requirements
- R1: After reset `pf_vld` is 0 and the table holds no entries, so the first training access for any program counter produces no prefetch.
- R2: A training access whose program counter matches no entry claims an entry with the address stored, stride 0 and confidence 0, and causes no prefetch.
- R3: A training access that matches an entry computes the stride as the new address minus the stored address (modulo 2^ADDR_W). The stored stride and address are always replaced by the new values, whatever happens to the confidence.
- R4: On a match, confidence goes up by one when the new stride equals the stored stride and down by one otherwise. It saturates at 3 and at 0.
- R5: A matching access starts a burst when its updated confidence is at least 2, its new stride is non-zero and `cfg_count` is non-zero. With a steady stride, the fourth access of a load is the first one that triggers.
- R6: The first address of a burst is the triggering address plus `cfg_dist` times the new stride. `cfg_dist` = 0 targets the triggering address itself.
- R7: A burst presents exactly `cfg_count` addresses, each one stride after the previous one. `pf_vld` is first high in the cycle after the triggering strobe.
- R8: While `pf_vld` is high and `pf_rdy` is low, `pf_vld` stays high and `pf_addr` does not change.
- R9: A trigger that arrives while a burst is still pending is dropped. Its access still trains the table.
- R10: The table has 16 entries. When all are in use, a miss evicts the entries in the order they were claimed, oldest first.
- R11: A stride of 0 or a `cfg_count` of 0 produces no prefetch, even at full confidence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| train_vld | input | 1 | Training access strobe |
| train_pc | input | PC_W | Program counter of the training load |
| train_addr | input | ADDR_W | Address referenced by the training load |
| cfg_dist | input | DIST_W | Lookahead distance in strides for the first prefetch |
| cfg_count | input | CNT_W | Number of prefetch addresses per burst |
| pf_vld | output | 1 | Prefetch address valid |
| pf_rdy | input | 1 | Consumer accepts the prefetch address |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
The assertions take `pf_rdy` as free to change in any cycle. They also assume that `cfg_dist` and `cfg_count` only matter at the cycle a burst starts, and that the table never holds two entries with the same tag, which the miss-only allocation guarantees. The stimulus changes the configuration only while no burst is pending. It gives each training sequence its own program counter, and it drives strobes half a cycle away from the sampling edge. The stalled-consumer case holds `pf_rdy` low across a second trigger before releasing it.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int CONF_W = 2;
  typedef logic [CONF_W-1:0] conf_t;
  localparam conf_t CONF_MAX = '1;

  // saturating confidence step: up on agreeing stride, down otherwise
  function automatic conf_t conf_step(input conf_t c, input logic agree);
    if (agree) return (c == CONF_MAX) ? c : c + conf_t'(1);
    return (c == '0) ? c : c - conf_t'(1);
  endfunction
endpackage

// File: rtl/pf_tag_match.sv
module pf_tag_match #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 16,
  parameter int IDX_W   = 4
) (
  input  logic [ENTRIES-1:0][PC_W-1:0] tags,
  input  logic [ENTRIES-1:0]           valids,
  input  logic [PC_W-1:0]              pc,
  output logic [ENTRIES-1:0]           hit_vec,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valids[g] && (tags[g] == pc);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end
endmodule

// File: rtl/pf_entry_store.sv
module pf_entry_store
  import pf_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 16,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         train_vld,
  input  logic [PC_W-1:0]              train_pc,
  input  logic [ADDR_W-1:0]            train_addr,
  input  logic                         hit,
  input  logic [IDX_W-1:0]             hit_idx,
  output logic [ENTRIES-1:0][PC_W-1:0] tags,
  output logic [ENTRIES-1:0]           valids,
  output logic [ADDR_W-1:0]            new_stride,
  output conf_t                        new_conf
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0][ADDR_W-1:0] last_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] stride_q;
  conf_t [ENTRIES-1:0]            conf_q;
  logic [IDX_W-1:0]               rr_q;

  function automatic logic [ADDR_W-1:0] stride_of(input logic [ADDR_W-1:0] now_a,
                                                   input logic [ADDR_W-1:0] prev_a);
    return now_a - prev_a;
  endfunction

  assign new_stride = stride_of(train_addr, last_q[hit_idx]);
  assign new_conf   = conf_step(conf_q[hit_idx], new_stride == stride_q[hit_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tags     <= '0;
      valids   <= '0;
      last_q   <= '0;
      stride_q <= '0;
      conf_q   <= '0;
      rr_q     <= '0;
    end else if (train_vld) begin
      if (hit) begin
        last_q[hit_idx]   <= train_addr;
        stride_q[hit_idx] <= new_stride;
        conf_q[hit_idx]   <= new_conf;
      end else begin
        valids[rr_q]   <= 1'b1;
        tags[rr_q]     <= train_pc;
        last_q[rr_q]   <= train_addr;
        stride_q[rr_q] <= '0;
        conf_q[rr_q]   <= '0;
        rr_q           <= (rr_q == LAST_IDX) ? '0 : rr_q + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/pf_burst_gen.sv
module pf_burst_gen #(
  parameter int ADDR_W = 32,
  parameter int DIST_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] start_stride,
  input  logic [DIST_W-1:0] cfg_dist,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              pf_rdy,
  output logic              pf_vld,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [ADDR_W-1:0] cur_stride,
  output logic [CNT_W-1:0]  left,
  output logic              start_taken
);
  // first target: base plus n strides, modulo 2^ADDR_W
  function automatic logic [ADDR_W-1:0] ahead(input logic [ADDR_W-1:0] base,
                                               input logic [ADDR_W-1:0] step,
                                               input logic [DIST_W-1:0] n);
    return base + ADDR_W'(n) * step;
  endfunction

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] stride_q;
  logic [CNT_W-1:0]  left_q;

  assign pf_vld      = (left_q != '0);
  assign pf_addr     = addr_q;
  assign cur_stride  = stride_q;
  assign left        = left_q;
  assign start_taken = start_req && !pf_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      stride_q <= '0;
      left_q   <= '0;
    end else if (start_taken) begin
      addr_q   <= ahead(start_addr, start_stride, cfg_dist);
      stride_q <= start_stride;
      left_q   <= cfg_count;
    end else if (pf_vld && pf_rdy) begin
      addr_q   <= addr_q + stride_q;
      left_q   <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/ldpc_stride_pf.sv
module ldpc_stride_pf
  import pf_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int PC_W        = 16,
  parameter int ADDR_W      = 32,
  parameter int DIST_W      = 3,
  parameter int CNT_W       = 3,
  parameter int CONF_THRESH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_vld,
  input  logic [PC_W-1:0]   train_pc,
  input  logic [ADDR_W-1:0] train_addr,
  input  logic [DIST_W-1:0] cfg_dist,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              pf_vld,
  input  logic              pf_rdy,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam conf_t THRESH = conf_t'(CONF_THRESH);

  logic [ENTRIES-1:0][PC_W-1:0] tags;
  logic [ENTRIES-1:0]           valids;
  logic [ENTRIES-1:0]           hit_vec;
  logic                         hit;
  logic [IDX_W-1:0]             hit_idx;
  logic [ADDR_W-1:0]            new_stride;
  conf_t                        new_conf;
  logic                         trig;
  logic                         trig_taken;
  logic [ADDR_W-1:0]            burst_stride;
  logic [CNT_W-1:0]             burst_left;

  pf_tag_match #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_match (
    .tags(tags), .valids(valids), .pc(train_pc),
    .hit_vec(hit_vec), .hit(hit), .hit_idx(hit_idx)
  );

  pf_entry_store #(.ENTRIES(ENTRIES), .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .train_vld(train_vld), .train_pc(train_pc),
    .train_addr(train_addr), .hit(hit), .hit_idx(hit_idx),
    .tags(tags), .valids(valids), .new_stride(new_stride), .new_conf(new_conf)
  );

  // trigger: confident hit with a usable stride and a non-empty burst
  assign trig = train_vld && hit && (new_conf >= THRESH) &&
                (new_stride != '0) && (cfg_count != '0);

  pf_burst_gen #(.ADDR_W(ADDR_W), .DIST_W(DIST_W), .CNT_W(CNT_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start_req(trig), .start_addr(train_addr),
    .start_stride(new_stride), .cfg_dist(cfg_dist), .cfg_count(cfg_count),
    .pf_rdy(pf_rdy), .pf_vld(pf_vld), .pf_addr(pf_addr),
    .cur_stride(burst_stride), .left(burst_left), .start_taken(trig_taken)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pf_vld,
  input logic               pf_rdy,
  input logic [ADDR_W-1:0]  pf_addr,
  input logic [ENTRIES-1:0] hit_vec,
  input logic               trig,
  input logic               trig_taken,
  input logic [ADDR_W-1:0]  burst_stride,
  input logic [CNT_W-1:0]   burst_left
);
  // R10: allocation on miss only, so at most one entry ever matches
  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R8: a stalled prefetch holds its address
  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld && !pf_rdy |=> pf_vld && $stable(pf_addr));

  // R7: an accepted address that is not the last is followed by the next stride
  assert_stride_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld && pf_rdy && (burst_left > 1) |=> pf_vld && (pf_addr == $past(pf_addr) + $past(burst_stride)));

  // R5: a burst only opens after an accepted trigger
  assert_burst_from_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf_vld) |-> $past(trig_taken));

  // R9: a trigger during a pending burst leaves the burst stride alone
  assert_drop_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig && pf_vld |=> $stable(burst_stride));

  // R11: no burst runs with a zero stride
  assert_nonzero_stride_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pf_vld |-> burst_stride != '0);
endmodule

bind ldpc_stride_pf pf_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pf_checker (
  .clk(clk), .rst_n(rst_n), .pf_vld(pf_vld), .pf_rdy(pf_rdy), .pf_addr(pf_addr),
  .hit_vec(hit_vec), .trig(trig), .trig_taken(trig_taken),
  .burst_stride(burst_stride), .burst_left(burst_left)
);

// File: tb/test_ldpc_stride_pf.sv
module test_ldpc_stride_pf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        train_vld = 1'b0;
  logic [15:0] train_pc = '0;
  logic [31:0] train_addr = '0;
  logic [2:0]  cfg_dist = '0;
  logic [2:0]  cfg_count = '0;
  logic        pf_vld;
  logic        pf_rdy = 1'b1;
  logic [31:0] pf_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldpc_stride_pf i_ldpc_stride_pf (
    .clk(clk), .rst_n(rst_n), .train_vld(train_vld), .train_pc(train_pc),
    .train_addr(train_addr), .cfg_dist(cfg_dist), .cfg_count(cfg_count),
    .pf_vld(pf_vld), .pf_rdy(pf_rdy), .pf_addr(pf_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pf_vld === 1'b0, "R1 reset valid", {31'b0, pf_vld}, 32'd0);
  endtask

  // strobe one training access; returns at the negedge after the sampling edge
  task automatic train(input logic [15:0] pc, input logic [31:0] addr);
    train_vld  = 1'b1;
    train_pc   = pc;
    train_addr = addr;
    @(negedge clk);
    train_vld  = 1'b0;
  endtask

  // with pf_rdy high, expect n addresses first, first+step, ...
  task automatic drain(input string req, input int n, input logic [31:0] first, input logic [31:0] step);
    for (int k = 0; k < n; k++) begin
      chk(pf_vld === 1'b1, req, {31'b0, pf_vld}, 32'd1);
      chk(pf_addr === first + 32'(k) * step, req, pf_addr, first + 32'(k) * step);
      @(negedge clk);
    end
    chk(pf_vld === 1'b0, req, {31'b0, pf_vld}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] pc_ctr;
    logic [31:0] strides [4];
    strides[0] = 32'd64;
    strides[1] = 32'hFFFF_FFC0;
    strides[2] = 32'd8;
    strides[3] = 32'd0;
    pc_ctr = 16'h0100;

    do_reset();

    // R2 R3 R5 R6 R7 R11: sweep distance, count and stride with steady sequences
    for (int d = 0; d < 8; d++) begin
      for (int c = 0; c < 5; c++) begin
        for (int si = 0; si < 4; si++) begin
          logic [31:0] s, base, a;
          int nexp;
          s = strides[si];
          base = 32'h2000_0000 + 32'(pc_ctr) * 32'h1000;
          cfg_dist  = 3'(d);
          cfg_count = 3'(c);
          for (int i = 0; i < 6; i++) begin
            a = base + 32'(i) * s;
            train(pc_ctr, a);
            nexp = (i >= 3 && s != 0) ? c : 0;
            if (i == 0) drain("R2 miss no prefetch", 0, 0, 0);
            else if (s == 0 || c == 0) drain("R11 zero stride or count", 0, 0, 0);
            else if (i < 3) drain("R5 below threshold", 0, 0, 0);
            else drain("R6 R7 burst", nexp, a + 32'(d) * s, s);
          end
          pc_ctr++;
        end
      end
    end

    // R4: saturation at 3, decrement on disagreement, stride always replaced (R3)
    begin
      logic [15:0] pc;
      logic [31:0] a;
      pc = 16'h5000;
      cfg_dist = 3'd1;
      cfg_count = 3'd1;
      a = 32'h4000_0000;
      for (int i = 0; i < 9; i++) begin
        train(pc, a + 32'(i) * 32'd16);
        if (i >= 3) drain("R4 saturating climb", 1, a + 32'(i + 1) * 32'd16, 32'd16);
        else drain("R4 saturating climb", 0, 0, 0);
      end
      a = a + 32'd8 * 32'd16;
      a = a + 32'd100;
      train(pc, a);
      drain("R4 first break keeps conf 2", 1, a + 32'd100, 32'd100);
      a = a + 32'd36;
      train(pc, a);
      drain("R4 second break drops to 1", 0, 0, 0);
      a = a + 32'd36;
      train(pc, a);
      drain("R3 R4 stored stride used", 1, a + 32'd36, 32'd36);
    end

    // R8 R9: stalled consumer, second trigger while pending
    begin
      logic [15:0] pc;
      logic [31:0] a;
      pc = 16'h6000;
      cfg_dist = 3'd2;
      cfg_count = 3'd3;
      pf_rdy = 1'b0;
      a = 32'h6000_0000;
      for (int i = 0; i < 4; i++) train(pc, a + 32'(i) * 32'd32);
      for (int k = 0; k < 3; k++) begin
        chk(pf_vld === 1'b1, "R8 stalled valid", {31'b0, pf_vld}, 32'd1);
        chk(pf_addr === a + 32'd5 * 32'd32, "R8 stalled addr", pf_addr, a + 32'd5 * 32'd32);
        @(negedge clk);
      end
      train(pc, a + 32'd4 * 32'd32);
      chk(pf_addr === a + 32'd5 * 32'd32, "R9 busy trigger dropped", pf_addr, a + 32'd5 * 32'd32);
      pf_rdy = 1'b1;
      drain("R9 only first burst", 3, a + 32'd5 * 32'd32, 32'd32);
      train(pc, a + 32'd5 * 32'd32);
      drain("R9 dropped access trained", 3, a + 32'd7 * 32'd32, 32'd32);
    end

    // R10: round-robin eviction after reset
    do_reset();
    begin
      logic [15:0] pc;
      logic [31:0] a;
      pc = 16'h7000;
      cfg_dist = 3'd1;
      cfg_count = 3'd2;
      a = 32'h7000_0000;
      for (int i = 0; i < 5; i++) begin
        train(pc, a + 32'(i) * 32'd64);
        if (i >= 3) drain("R10 warm", 2, a + 32'(i + 1) * 32'd64, 32'd64);
        else drain("R10 warm", 0, 0, 0);
      end
      for (int j = 0; j < 15; j++) begin
        train(16'h9000 + 16'(j), 32'h9000_0000 + 32'(j) * 32'h100);
        drain("R10 filler miss", 0, 0, 0);
      end
      train(pc, a + 32'd5 * 32'd64);
      drain("R10 still resident with 16 used", 2, a + 32'd6 * 32'd64, 32'd64);
      train(16'h9100, 32'h9100_0000);
      drain("R10 evicting miss", 0, 0, 0);
      for (int i = 6; i < 10; i++) begin
        train(pc, a + 32'(i) * 32'd64);
        if (i < 9) drain("R10 oldest evicted", 0, 0, 0);
        else drain("R10 relearned", 2, a + 32'd10 * 32'd64, 32'd64);
      end
    end

    report();
  end
endmodule